// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block holds the applied gain codes for the left and right halves of a stereo programmable-gain stage and decides when a newly written gain code reaches each half. With zero-cross mode on, a write only arms a change: each channel keeps its old code until its own audio signal changes sign between two samples. If no crossing arrives, the change is forced when a shared timeout expires. With zero-cross mode off, a written code reaches both channels at once. Applying the change at a crossing stops a gain step from landing in the middle of a large sample, which would produce a click.

The sample tick marks one audio sample period. The two sign inputs carry the sign bit of each channel's current sample, and only their values at ticks matter. After reset both channels are muted (code 00h). They stay muted through a calibration window of a fixed number of sample ticks, and writes made during that window are dropped. The timeout is a multiple of a base number of samples. The multiplier is chosen per write and is 8 after reset, which gives 2048 samples at the default base of 256.

Top module: `zcg_top`

## Requirements
- R1: After reset both applied codes are 00h (mute).
- R2: For the first CAL_TICKS sample ticks after reset, write strobes are ignored and both codes stay 00h.
- R3: An accepted write with zero-cross mode off puts the written code on both outputs in the next clock cycle.
- R4: An accepted write with zero-cross mode on leaves both outputs unchanged. A channel adopts the target code in the cycle after a sample tick at which its sign bit differs from its sign bit at the previous tick.
- R5: The channels commit independently: a crossing on one channel does not change the other channel's code.
- R6: A channel still pending adopts the target in the cycle after the N-th sample tick counted from the last accepted write, where N = TMO_BASE × 2^sel and sel is the 2-bit timeout select captured with that write (0→×1, 1→×2, 2→×4, 3→×8; the select is 3 after reset).
- R7: A zero-cross write while a change is pending restarts the timeout count and retargets both channels. A channel that has already committed keeps its intermediate code until its own next crossing or the new timeout.
- R8: With no change pending, sign changes and ticks leave both codes unchanged.
- R9: When a write and a sample tick fall in the same cycle, the write takes priority and no commit happens in that cycle. The tick's sign value still becomes the reference for the next crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle write strobe for a new gain code |
| wr_gain | input | GAIN_W | Gain code to write |
| zc_en | input | 1 | Zero-cross mode enable, sampled with the write |
| tmo_sel | input | 2 | Timeout multiplier select, captured with a zero-cross write |
| smp_tick | input | 1 | One-cycle pulse per audio sample |
| sign_l | input | 1 | Sign bit of the current left sample |
| sign_r | input | 1 | Sign bit of the current right sample |
| gain_l | output | GAIN_W | Applied left gain code |
| gain_r | output | GAIN_W | Applied right gain code |

## Verification
The bench builds the block with TMO_BASE = 4 and CAL_TICKS = 8, keeping GAIN_W at 7. A timeout therefore lasts 4, 8, 16 or 32 sample ticks, so every select value, including the largest, runs to expiry many times within a short random run. The calibration window closes after eight ticks, which puts the dropped-write phase and its exit in the directed part of the bench. Because timeouts are short, random writes often land while a change is still pending, and that is where the two channels can end up at different codes.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

    typedef enum logic [1:0] {
        TMO_X1 = 2'd0,
        TMO_X2 = 2'd1,
        TMO_X4 = 2'd2,
        TMO_X8 = 2'd3
    } tmo_mul_e;

    localparam int unsigned MUL_MAX = 8;

    function automatic int unsigned tmo_scale(tmo_mul_e s);
        return 32'd1 << s;
    endfunction

endpackage

// File: rtl/zcg_timer.sv
module zcg_timer #(
    parameter int unsigned TMO_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              halt,
    input  zcg_pkg::tmo_mul_e sel_in,
    input  logic              tick,
    input  logic              any_pend,
    output logic              expire
);
    import zcg_pkg::*;

    localparam int unsigned CNT_W = $clog2(TMO_BASE * MUL_MAX);
    localparam int unsigned LIM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        tmo_mul_e         sel;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [LIM_W-1:0] lim;

    always_comb begin
        lim    = LIM_W'(TMO_BASE * tmo_scale(st_q.sel));
        expire = st_q.run && tick && ({1'b0, st_q.cnt} == lim - LIM_W'(1));
        st_d   = st_q;
        if (restart) begin
            st_d.cnt = '0;
            st_d.run = 1'b1;
            st_d.sel = sel_in;
        end else if (halt) begin
            st_d.cnt = '0;
            st_d.run = 1'b0;
        end else if (st_q.run) begin
            if (!any_pend) begin
                st_d.cnt = '0;
                st_d.run = 1'b0;
            end else if (tick) begin
                if (expire) begin
                    st_d.cnt = '0;
                    st_d.run = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, run: 1'b0, sel: TMO_X8};
        end else begin
            st_q <= st_d;
        end
    end

    a_r6_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> ({1'b0, st_q.cnt} < lim));
    a_r6_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !restart) |=> !st_q.run);
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.run && st_q.cnt == '0));

endmodule

// File: rtl/zcg_chan.sv
module zcg_chan #(
    parameter int unsigned GAIN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [GAIN_W-1:0] wr_code,
    input  logic              zc_en,
    input  logic [GAIN_W-1:0] target,
    input  logic              tick,
    input  logic              sgn,
    input  logic              expire,
    output logic [GAIN_W-1:0] gain,
    output logic              pend
);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              pend;
        logic              prev;
    } chan_t;

    chan_t st_d, st_q;
    logic  crossed;

    always_comb begin
        crossed = tick && (sgn != st_q.prev);
        st_d    = st_q;
        if (tick) begin
            st_d.prev = sgn;
        end
        if (wr_acc) begin
            if (!zc_en) begin
                st_d.gain = wr_code;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
            end
        end else if (st_q.pend && (crossed || expire)) begin
            st_d.gain = target;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain = st_q.gain;
    assign pend = st_q.pend;

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && !wr_acc) |=> $stable(st_q.gain));
    a_r3_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !zc_en) |=> (st_q.gain == $past(wr_code)));
    a_r4_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && zc_en) |=> (st_q.pend && $stable(st_q.gain)));
    a_r4_commit_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.pend) && !$past(wr_acc)) |-> (st_q.gain == target));

endmodule

// File: rtl/zcg_top.sv
module zcg_top #(
    parameter int unsigned GAIN_W    = 7,
    parameter int unsigned TMO_BASE  = 256,
    parameter int unsigned CAL_TICKS = 4128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [GAIN_W-1:0] wr_gain,
    input  logic              zc_en,
    input  logic [1:0]        tmo_sel,
    input  logic              smp_tick,
    input  logic              sign_l,
    input  logic              sign_r,
    output logic [GAIN_W-1:0] gain_l,
    output logic [GAIN_W-1:0] gain_r
);
    import zcg_pkg::*;

    localparam int unsigned CAL_W = $clog2(CAL_TICKS + 2);
    localparam int unsigned NCH   = 2;

    typedef struct packed {
        logic [GAIN_W-1:0] tgt;
        logic [CAL_W-1:0]  cal;
    } top_t;

    top_t st_d, st_q;
    logic cal_done, wr_acc, expire;
    logic [NCH-1:0]    sgn_v, pend_v;
    logic [GAIN_W-1:0] gain_v [NCH];

    always_comb begin
        cal_done = (st_q.cal >= CAL_W'(CAL_TICKS));
        wr_acc   = wr_stb && cal_done;
        st_d     = st_q;
        if (smp_tick && !cal_done) begin
            st_d.cal = st_q.cal + CAL_W'(1);
        end
        if (wr_acc) begin
            st_d.tgt = wr_gain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    zcg_timer #(.TMO_BASE(TMO_BASE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_acc && zc_en),
        .halt     (wr_acc && !zc_en),
        .sel_in   (tmo_mul_e'(tmo_sel)),
        .tick     (smp_tick),
        .any_pend (|pend_v),
        .expire   (expire)
    );

    assign sgn_v = {sign_r, sign_l};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        zcg_chan #(.GAIN_W(GAIN_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_acc  (wr_acc),
            .wr_code (wr_gain),
            .zc_en   (zc_en),
            .target  (st_q.tgt),
            .tick    (smp_tick),
            .sgn     (sgn_v[c]),
            .expire  (expire),
            .gain    (gain_v[c]),
            .pend    (pend_v[c])
        );
    end

    assign gain_l = gain_v[0];
    assign gain_r = gain_v[1];

    a_r2_cal_mute: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> (gain_l == '0 && gain_r == '0));
    a_r2_cal_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> (pend_v == '0));

endmodule

// File: tb/zcg_top_tb.sv
module zcg_top_tb;
    localparam int GW   = 7;
    localparam int BASE = 4;
    localparam int CAL  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0;
    logic [GW-1:0] wr_gain = '0;
    logic zc_en = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic smp_tick = 1'b0;
    logic sign_l = 1'b0;
    logic sign_r = 1'b0;
    logic [GW-1:0] gain_l, gain_r;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    logic [GW-1:0] m_tgt, m_gl, m_gr;
    bit m_pl, m_pr, m_prl, m_prr, m_run;
    int m_cnt, m_sel, m_cal;

    always #5 clk = ~clk;

    zcg_top #(.GAIN_W(GW), .TMO_BASE(BASE), .CAL_TICKS(CAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_gain(wr_gain),
        .zc_en(zc_en), .tmo_sel(tmo_sel), .smp_tick(smp_tick),
        .sign_l(sign_l), .sign_r(sign_r), .gain_l(gain_l), .gain_r(gain_r)
    );

    task automatic chk(input string tag, input logic [GW-1:0] act, input logic [GW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tgt = '0; m_gl = '0; m_gr = '0;
        m_pl = 0; m_pr = 0; m_prl = 0; m_prr = 0; m_run = 0;
        m_cnt = 0; m_sel = 3; m_cal = 0;
    endtask

    // one channel update, computed from the requirements
    function automatic void chan_next(input bit acc, input bit zc, input logic [GW-1:0] code,
                                      input bit tk, input bit s, input bit prv, input bit ex,
                                      input logic [GW-1:0] tgt,
                                      inout logic [GW-1:0] g, inout bit p);
        if (acc) begin
            if (!zc) begin g = code; p = 0; end
            else p = 1;
        end else if (p && tk && ((s != prv) || ex)) begin
            g = tgt; p = 0;
        end
    endfunction

    task automatic model_step(input bit wr, input logic [GW-1:0] code, input bit zc,
                              input int sel, input bit tk, input bit sl, input bit sr);
        bit acc, ex, any_p;
        acc   = wr && (m_cal >= CAL);
        ex    = m_run && tk && (m_cnt == (BASE << m_sel) - 1);
        any_p = m_pl || m_pr;
        chan_next(acc, zc, code, tk, sl, m_prl, ex, m_tgt, m_gl, m_pl);
        chan_next(acc, zc, code, tk, sr, m_prr, ex, m_tgt, m_gr, m_pr);
        if (acc && zc) begin m_cnt = 0; m_run = 1; m_sel = sel; end
        else if (acc) begin m_cnt = 0; m_run = 0; end
        else if (m_run) begin
            if (!any_p) begin m_cnt = 0; m_run = 0; end
            else if (tk) begin
                if (ex) begin m_cnt = 0; m_run = 0; end
                else m_cnt++;
            end
        end
        if (acc) m_tgt = code;
        if (tk) begin m_prl = sl; m_prr = sr; end
        if (tk && m_cal < CAL) m_cal++;
    endtask

    task automatic step(input bit wr, input logic [GW-1:0] code, input bit zc, input int sel,
                        input bit tk, input bit sl, input bit sr, input string tag);
        wr_stb = wr; wr_gain = code; zc_en = zc; tmo_sel = 2'(sel);
        smp_tick = tk; sign_l = sl; sign_r = sr;
        @(posedge clk);
        model_step(wr, code, zc, sel, tk, sl, sr);
        @(negedge clk);
        wr_stb = 0; smp_tick = 0;
        chk(tag, gain_l, m_gl);
        chk(tag, gain_r, m_gr);
    endtask

    task automatic tk(input bit sl, input bit sr, input string tag);
        step(0, '0, 0, 0, 1, sl, sr, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 left", gain_l, 7'h00);
        chk("R1 right", gain_r, 7'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: writes during calibration window are dropped
        for (int i = 0; i < CAL; i++) step(1, 7'h11, 0, 0, 1, 0, 0, "R2");
        chk("R2 left mute", gain_l, 7'h00);
        chk("R2 right mute", gain_r, 7'h00);

        // R3: direct write
        step(1, 7'h28, 0, 0, 0, 0, 0, "R3");
        chk("R3 left", gain_l, 7'h28);
        chk("R3 right", gain_r, 7'h28);

        // R4 / R5 / R6: armed write, left crossing, right by timeout (N=4)
        step(1, 7'h30, 1, 0, 0, 0, 0, "R4");
        chk("R4 held", gain_l, 7'h28);
        tk(0, 0, "R4");
        chk("R4 no cross", gain_l, 7'h28);
        tk(1, 0, "R5");
        chk("R4 left commit", gain_l, 7'h30);
        chk("R5 right untouched", gain_r, 7'h28);
        tk(1, 0, "R6");
        chk("R6 before expiry", gain_r, 7'h28);
        tk(1, 0, "R6");
        chk("R6 expiry", gain_r, 7'h30);

        // R7: rewrite while pending leaves channels apart
        step(1, 7'h31, 1, 0, 0, 1, 0, "R7");
        tk(0, 0, "R7");
        chk("R7 left 31", gain_l, 7'h31);
        step(1, 7'h32, 1, 0, 0, 0, 0, "R7");
        tk(0, 1, "R7");
        chk("R7 right 32", gain_r, 7'h32);
        chk("R7 left keeps 31", gain_l, 7'h31);
        tk(0, 1, "R7");
        tk(0, 1, "R7");
        chk("R7 left still 31", gain_l, 7'h31);
        tk(0, 1, "R7");
        chk("R7 left timeout 32", gain_l, 7'h32);

        // R8: idle sign changes do nothing
        for (int i = 0; i < 6; i++) tk(i[0], ~i[0], "R8");
        chk("R8 left", gain_l, 7'h32);
        chk("R8 right", gain_r, 7'h32);

        // R9: write and tick together, write wins
        step(1, 7'h40, 1, 0, 1, 0, 0, "R9");
        chk("R9 no commit", gain_l, 7'h32);
        tk(0, 0, "R9");
        chk("R9 new reference", gain_l, 7'h32);

        // R6: select 1 (N=8) and select 3 (N=32)
        step(1, 7'h20, 1, 1, 0, 0, 0, "R6");
        for (int i = 0; i < 7; i++) tk(0, 0, "R6");
        chk("R6 sel1 before", gain_l, 7'h32);
        tk(0, 0, "R6");
        chk("R6 sel1 expiry", gain_l, 7'h20);
        step(1, 7'h21, 1, 3, 0, 0, 0, "R6");
        for (int i = 0; i < 31; i++) tk(0, 0, "R6");
        chk("R6 sel3 before", gain_r, 7'h20);
        tk(0, 0, "R6");
        chk("R6 sel3 expiry", gain_r, 7'h21);

        // constrained random phase
        begin
            bit sl, sr;
            void'($urandom(32'h5EED1234));
            sl = 0; sr = 0;
            for (int i = 0; i < 5000; i++) begin
                bit w, t;
                w = ($urandom_range(0, 11) == 0);
                t = ($urandom_range(0, 1) == 1);
                if (t && $urandom_range(0, 7) == 0) sl = ~sl;
                if (t && $urandom_range(0, 7) == 0) sr = ~sr;
                step(w, GW'($urandom_range(0, 127)), ($urandom_range(0, 3) != 0),
                     $urandom_range(0, 3), t, sl, sr, "RAND");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule